// File: doc/BRIEF.md
# PCIe Configuration Window Address Translator

This block sits between a memory-mapped slave port and the configuration request interface of a PCIe core. Software reaches configuration space through a 64 KB window. The lower 32 KB of the window is divided into eight 4 KB regions. Each region is tied to a 16-bit target register that holds the bus, device and function numbers. When the window is accessed, the block takes the target from the register of the selected region and builds the core-side configuration address. It then issues a Type 0 request for region 0 and a Type 1 request for every other region. It forwards the request, waits for the core's completion and returns one response to the slave.

The target registers are loaded and read back over a separate 32-bit register port, with two registers packed into each word. After writing a target, software reads it back to flush the write, and then accesses the window. A configuration read that ends in an error completion returns all ones instead of an error, so enumeration software sees a missing device rather than a bus fault. Only one request is in flight at a time.

Top module: `cfg_win_xlat`

## Requirements
- R1: After reset all eight target registers read as zero, `s_ready_o` is 1, and `c_valid_o` and `s_rvalid_o` are 0.
- R2: Register-port word w holds target register 2w in bits [15:0] and target register 2w+1 in bits [31:16]. Each byte is written only when its bit in `reg_be_i` is set, and `reg_rdata_o` shows the word at `reg_addr_i` in the same cycle.
- R3: For a window address A with A[15]=0, `c_addr_o` = {target[A[14:12]], 4'b0000, A[11:2], 2'b00}. A[1:0] has no effect.
- R4: `c_type1_o` is 0 when A[15:12] is zero and 1 otherwise.
- R5: An access with A[15]=1 raises no core request. It is answered on the cycle after acceptance with `s_err_o`=1 and `s_rdata_o`=32'hFFFF_FFFF.
- R6: A read completion without error returns its data with `s_err_o`=0. A read completion with error returns 32'hFFFF_FFFF with `s_err_o`=0.
- R7: For a write, `c_we_o`=1 and `c_wdata_o` and `c_be_o` equal the slave's write data and byte enables. The response carries `s_rdata_o`=0 and `s_err_o`=0, even after an error completion.
- R8: An access is accepted only when `s_ready_o` is 1. `s_ready_o` stays 0 from the cycle after acceptance until the response has been taken.
- R9: `c_valid_o` is raised on the cycle after acceptance and holds with stable fields until `c_ready_i`. `s_rvalid_o` holds with stable data until `s_rready_i`.
- R10: A target register written while a request is in flight does not change that request's `c_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 2 | Register port word address |
| reg_wdata_i | input | 32 | Register port write data |
| reg_be_i | input | 4 | Register port byte enables |
| reg_rdata_o | output | 32 | Register port read data |
| s_valid_i | input | 1 | Window access request valid |
| s_ready_o | output | 1 | Window access accepted |
| s_we_i | input | 1 | Window access is a write |
| s_addr_i | input | 16 | Window byte address |
| s_wdata_i | input | 32 | Window write data |
| s_be_i | input | 4 | Window write byte enables |
| s_rvalid_o | output | 1 | Response valid |
| s_rready_i | input | 1 | Response taken |
| s_rdata_o | output | 32 | Response read data |
| s_err_o | output | 1 | Response error |
| c_valid_o | output | 1 | Config request valid |
| c_ready_i | input | 1 | Config request accepted by core |
| c_we_o | output | 1 | Config request is a write |
| c_type1_o | output | 1 | Config request is Type 1 |
| c_addr_o | output | 32 | Core-side config address |
| c_wdata_o | output | 32 | Config write data |
| c_be_o | output | 4 | Config write byte enables |
| c_cpl_valid_i | input | 1 | Completion valid |
| c_cpl_ready_o | output | 1 | Block is waiting for a completion |
| c_cpl_data_i | input | 32 | Completion read data |
| c_cpl_err_i | input | 1 | Completion reports an error |

## Verification
The assertions assume the core raises `c_cpl_valid_i` only while `c_cpl_ready_o` is high. They also assume the core sends exactly one completion per accepted request. The stimulus follows both rules, because the bench's core model drives one completion pulse only after it sees `c_cpl_ready_o`. The slave side of the bench raises `s_valid_i` only for a single cycle while `s_ready_o` is high, and it never starts a new access before the previous response has been taken.

// File: rtl/cfg_win_pkg.sv
package cfg_win_pkg;
  localparam int DW    = 32;
  localparam int CAW   = 32;
  localparam int BDF_W = 16;
  localparam int BEW   = DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } xlat_st_e;

  typedef struct packed {
    logic           we;
    logic           type1;
    logic [CAW-1:0] addr;
    logic [DW-1:0]  wdata;
    logic [BEW-1:0] be;
  } cfg_req_t;
endpackage

// File: rtl/bdf_reg_bank.sv
module bdf_reg_bank
  import cfg_win_pkg::*;
#(
  parameter int NUM_BDF = 8,
  localparam int WORDS  = NUM_BDF / 2,
  localparam int AW     = $clog2(WORDS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [DW-1:0]                    wdata_i,
  input  logic [BEW-1:0]                   be_i,
  output logic [DW-1:0]                    rdata_o,
  output logic [NUM_BDF-1:0][BDF_W-1:0]    bdf_o
);
  logic [NUM_BDF-1:0][BDF_W-1:0] regs_q;

  for (genvar r = 0; r < NUM_BDF; r++) begin : g_reg
    localparam int WIDX = r / 2;
    localparam int HALF = r % 2;
    for (genvar b = 0; b < BDF_W / 8; b++) begin : g_byte
      localparam int LANE = HALF * (BDF_W / 8) + b;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[r][b*8 +: 8] <= '0;
        else if (we_i && addr_i == AW'(WIDX) && be_i[LANE])
          regs_q[r][b*8 +: 8] <= wdata_i[LANE*8 +: 8];
      end
    end
  end

  assign rdata_o = {regs_q[{addr_i, 1'b1}], regs_q[{addr_i, 1'b0}]};
  assign bdf_o   = regs_q;
endmodule

// File: rtl/cfg_addr_compose.sv
module cfg_addr_compose
  import cfg_win_pkg::*;
#(
  parameter int NUM_BDF = 8,
  parameter int WIN_AW  = 16,
  localparam int RGN_W  = $clog2(NUM_BDF)
) (
  input  logic [WIN_AW-1:0]              win_addr_i,
  input  logic [NUM_BDF-1:0][BDF_W-1:0]  bdf_i,
  output logic [CAW-1:0]                 cfg_addr_o,
  output logic                           type1_o,
  output logic                           upper_o
);
  logic [RGN_W-1:0] region;
  logic             unused_low;

  assign region     = win_addr_i[12 +: RGN_W];
  assign upper_o    = win_addr_i[WIN_AW-1];
  // any nonzero region selector means the target sits behind a bridge
  assign type1_o    = |win_addr_i[WIN_AW-1:12];
  assign cfg_addr_o = {bdf_i[region], 4'b0000, win_addr_i[11:2], 2'b00};
  assign unused_low = ^win_addr_i[1:0];
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import cfg_win_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           s_valid_i,
  output logic           s_ready_o,
  input  cfg_req_t       nxt_req_i,
  input  logic           upper_i,
  output logic           s_rvalid_o,
  input  logic           s_rready_i,
  output logic [DW-1:0]  s_rdata_o,
  output logic           s_err_o,
  output logic           c_valid_o,
  input  logic           c_ready_i,
  output cfg_req_t       c_req_o,
  input  logic           c_cpl_valid_i,
  output logic           c_cpl_ready_o,
  input  logic [DW-1:0]  c_cpl_data_i,
  input  logic           c_cpl_err_i
);
  xlat_st_e      st_q;
  cfg_req_t      req_q;
  logic [DW-1:0] rsp_data_q;
  logic          rsp_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      req_q      <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (s_valid_i) begin
          req_q <= nxt_req_i;  // target snapshot taken here
          if (upper_i) begin
            rsp_data_q <= '1;
            rsp_err_q  <= 1'b1;
            st_q       <= ST_RSP;
          end else begin
            st_q <= ST_REQ;
          end
        end
        ST_REQ: if (c_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (c_cpl_valid_i) begin
          rsp_err_q <= 1'b0;
          if (req_q.we)         rsp_data_q <= '0;
          else if (c_cpl_err_i) rsp_data_q <= '1;
          else                  rsp_data_q <= c_cpl_data_i;
          st_q <= ST_RSP;
        end
        ST_RSP: if (s_rready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign s_ready_o     = (st_q == ST_IDLE);
  assign c_valid_o     = (st_q == ST_REQ);
  assign c_cpl_ready_o = (st_q == ST_WAIT);
  assign s_rvalid_o    = (st_q == ST_RSP);
  assign s_rdata_o     = rsp_data_q;
  assign s_err_o       = rsp_err_q;
  assign c_req_o       = req_q;
endmodule

// File: rtl/cfg_win_xlat.sv
module cfg_win_xlat
  import cfg_win_pkg::*;
#(
  parameter int NUM_BDF = 8,
  parameter int WIN_AW  = 16,
  localparam int RAW    = $clog2(NUM_BDF / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [3:0]        reg_be_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic              s_we_i,
  input  logic [WIN_AW-1:0] s_addr_i,
  input  logic [31:0]       s_wdata_i,
  input  logic [3:0]        s_be_i,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic [31:0]       s_rdata_o,
  output logic              s_err_o,
  output logic              c_valid_o,
  input  logic              c_ready_i,
  output logic              c_we_o,
  output logic              c_type1_o,
  output logic [31:0]       c_addr_o,
  output logic [31:0]       c_wdata_o,
  output logic [3:0]        c_be_o,
  input  logic              c_cpl_valid_i,
  output logic              c_cpl_ready_o,
  input  logic [31:0]       c_cpl_data_i,
  input  logic              c_cpl_err_i
);
  logic [NUM_BDF-1:0][BDF_W-1:0] bdf;
  cfg_req_t nxt_req, cur_req;
  logic     upper;

  bdf_reg_bank #(.NUM_BDF(NUM_BDF)) u_bank (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .be_i(reg_be_i), .rdata_o(reg_rdata_o), .bdf_o(bdf)
  );

  cfg_addr_compose #(.NUM_BDF(NUM_BDF), .WIN_AW(WIN_AW)) u_comp (
    .win_addr_i(s_addr_i), .bdf_i(bdf),
    .cfg_addr_o(nxt_req.addr), .type1_o(nxt_req.type1), .upper_o(upper)
  );

  assign nxt_req.we    = s_we_i;
  assign nxt_req.wdata = s_wdata_i;
  assign nxt_req.be    = s_be_i;

  xlat_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .s_valid_i, .s_ready_o, .nxt_req_i(nxt_req), .upper_i(upper),
    .s_rvalid_o, .s_rready_i, .s_rdata_o, .s_err_o,
    .c_valid_o, .c_ready_i, .c_req_o(cur_req),
    .c_cpl_valid_i, .c_cpl_ready_o, .c_cpl_data_i, .c_cpl_err_i
  );

  assign c_we_o    = cur_req.we;
  assign c_type1_o = cur_req.type1;
  assign c_addr_o  = cur_req.addr;
  assign c_wdata_o = cur_req.wdata;
  assign c_be_o    = cur_req.be;
endmodule

// File: rtl/cfg_win_xlat_chk.sv
module cfg_win_xlat_chk #(
  parameter int WIN_AW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [WIN_AW-1:0] s_addr_i,
  input logic              s_rvalid_o,
  input logic              s_rready_i,
  input logic [31:0]       s_rdata_o,
  input logic              s_err_o,
  input logic              c_valid_o,
  input logic              c_ready_i,
  input logic [31:0]       c_addr_o,
  input logic              c_type1_o
);
  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_valid_o || s_rvalid_o) |-> !s_ready_o);

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_valid_o && !c_ready_i) |=> (c_valid_o && $stable(c_addr_o) && $stable(c_type1_o)));

  a_r9_rsp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_rvalid_o && !s_rready_i) |=> (s_rvalid_o && $stable(s_rdata_o) && $stable(s_err_o)));

  a_r5_upper_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o && s_addr_i[WIN_AW-1]) |=>
      (!c_valid_o && s_rvalid_o && s_err_o && s_rdata_o == 32'hFFFF_FFFF));

  a_r9_req_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o && !s_addr_i[WIN_AW-1]) |=> c_valid_o);

  a_r3_zero_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> (c_addr_o[15:12] == 4'b0000 && c_addr_o[1:0] == 2'b00));
endmodule

bind cfg_win_xlat cfg_win_xlat_chk #(.WIN_AW(WIN_AW)) u_chk (.*);

// File: tb/cfg_win_xlat_test.sv
module cfg_win_xlat_test;
  localparam time CLK_P = 10ns;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0; logic [3:0] reg_be = 0;
  logic [31:0] reg_rdata;
  logic s_valid = 0, s_we = 0, s_rready = 0; logic [15:0] s_addr = 0;
  logic [31:0] s_wdata = 0; logic [3:0] s_be = 0;
  logic s_ready, s_rvalid, s_err; logic [31:0] s_rdata;
  logic c_valid, c_we, c_type1, c_cpl_ready; logic [31:0] c_addr, c_wdata; logic [3:0] c_be;
  logic c_ready = 0, c_cpl_valid = 0, c_cpl_err = 0; logic [31:0] c_cpl_data = 0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_win_xlat uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_be_i(reg_be),
    .reg_rdata_o(reg_rdata),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_we_i(s_we), .s_addr_i(s_addr),
    .s_wdata_i(s_wdata), .s_be_i(s_be), .s_rvalid_o(s_rvalid), .s_rready_i(s_rready),
    .s_rdata_o(s_rdata), .s_err_o(s_err),
    .c_valid_o(c_valid), .c_ready_i(c_ready), .c_we_o(c_we), .c_type1_o(c_type1),
    .c_addr_o(c_addr), .c_wdata_o(c_wdata), .c_be_o(c_be),
    .c_cpl_valid_i(c_cpl_valid), .c_cpl_ready_o(c_cpl_ready),
    .c_cpl_data_i(c_cpl_data), .c_cpl_err_i(c_cpl_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] w, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_we = 1; reg_addr = w; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_chk(string req, logic [1:0] w, logic [31:0] exp);
    reg_addr = w; #1;
    chk(req, reg_rdata, exp);
  endtask

  // One window access with a core model; poke writes ones into word pw mid-flight.
  task automatic win_txn(string req, logic we, logic [15:0] a, logic [31:0] wd, logic [3:0] be,
                         logic [31:0] cpl_d, logic cpl_e, logic [31:0] exp_ca, logic exp_t1,
                         logic [31:0] exp_rd, logic exp_err, logic poke, logic [1:0] pw);
    @(negedge clk);
    chk({req, " R8 ready before"}, 32'(s_ready), 1);
    s_valid = 1; s_we = we; s_addr = a; s_wdata = wd; s_be = be;
    @(negedge clk);
    s_valid = 0;
    chk({req, " R8 busy"}, 32'(s_ready), 0);
    if (a[15]) begin
      chk({req, " R5 no req"}, 32'(c_valid), 0);
    end else begin
      chk({req, " R9 req valid"}, 32'(c_valid), 1);
      chk({req, " R3 addr"}, c_addr, exp_ca);
      chk({req, " R4 type"}, 32'(c_type1), 32'(exp_t1));
      chk({req, " R7 we"}, 32'(c_we), 32'(we));
      if (we) begin
        chk({req, " R7 wdata"}, c_wdata, wd);
        chk({req, " R7 be"}, 32'(c_be), 32'(be));
      end
      if (poke) begin
        reg_we = 1; reg_addr = pw; reg_wdata = '1; reg_be = 4'hF;
      end
      @(negedge clk);
      reg_we = 0;
      chk({req, " R9 req held"}, 32'(c_valid), 1);
      chk({req, " R10 addr kept"}, c_addr, exp_ca);
      c_ready = 1;
      @(negedge clk);
      c_ready = 0;
      chk({req, " R9 req dropped"}, 32'(c_valid), 0);
      chk({req, " R8 wait cpl"}, 32'(c_cpl_ready), 1);
      c_cpl_valid = 1; c_cpl_data = cpl_d; c_cpl_err = cpl_e;
      @(negedge clk);
      c_cpl_valid = 0;
    end
    chk({req, " R9 rvalid"}, 32'(s_rvalid), 1);
    chk({req, " R6 rdata"}, s_rdata, exp_rd);
    chk({req, " R6 err"}, 32'(s_err), 32'(exp_err));
    @(negedge clk);
    chk({req, " R9 rsp held"}, 32'(s_rvalid), 1);
    chk({req, " R9 rdata held"}, s_rdata, exp_rd);
    chk({req, " R8 busy in rsp"}, 32'(s_ready), 0);
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
    chk({req, " R8 rsp done"}, 32'(s_rvalid), 0);
    chk({req, " R8 ready again"}, 32'(s_ready), 1);
  endtask

  task automatic t_reset;
    for (int w = 0; w < 4; w++) reg_chk("R1 reg zero", 2'(w), 32'h0);
    chk("R1 s_ready", 32'(s_ready), 1);
    chk("R1 c_valid", 32'(c_valid), 0);
    chk("R1 s_rvalid", 32'(s_rvalid), 0);
  endtask

  task automatic t_regs;
    reg_wr(2'd0, 32'h0208_0100, 4'hF);
    reg_chk("R2 word0", 2'd0, 32'h0208_0100);
    reg_wr(2'd1, 32'hAABB_CCDD, 4'b0100);
    reg_chk("R2 byte enable", 2'd1, 32'h00BB_0000);
    reg_wr(2'd3, 32'h1234_5678, 4'b1100);
    reg_chk("R2 high half", 2'd3, 32'h1234_0000);
    reg_chk("R2 other untouched", 2'd2, 32'h0);
  endtask

  task automatic t_type0_read;
    win_txn("R3 type0 read", 0, 16'h0007, 0, 0, 32'h1234_5678, 0,
            32'h0100_0004, 0, 32'h1234_5678, 0, 0, 0);
  endtask

  task automatic t_type1_err_read;
    win_txn("R6 type1 err read", 0, 16'h1ABC, 0, 0, 32'h5555_5555, 1,
            32'h0208_0ABC, 1, 32'hFFFF_FFFF, 0, 0, 0);
  endtask

  task automatic t_write;
    win_txn("R7 write rgn3", 1, 16'h3012, 32'hCAFE_F00D, 4'b0101, 32'h9999_9999, 0,
            32'h00BB_0010, 1, 32'h0, 0, 0, 0);
    win_txn("R7 write err cpl", 1, 16'h0100, 32'h0BAD_CAFE, 4'hF, 32'h0, 1,
            32'h0100_0100, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic t_upper;
    win_txn("R5 upper read", 0, 16'h8000, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, 0, 0);
    win_txn("R5 upper write", 1, 16'hF004, 32'h1, 4'hF, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, 0, 0);
  endtask

  task automatic t_snapshot;
    win_txn("R10 snapshot rgn2", 0, 16'h2020, 0, 0, 32'hA5A5_A5A5, 0,
            32'h0000_0020, 1, 32'hA5A5_A5A5, 0, 1, 2'd1);
    reg_chk("R10 poke landed", 2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_region7;
    win_txn("R3 rgn7 top", 0, 16'h7FFD, 0, 0, 32'h0000_0001, 0,
            32'h1234_0FFC, 1, 32'h0000_0001, 0, 0, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_type0_read();
    t_type1_err_read();
    t_write();
    t_upper();
    t_snapshot();
    t_region7();
    summary();
  end
endmodule